// File: doc/BRIEF.md
# CIC Decimator Gain Corrector

This block sits behind a cascaded integrator-comb decimator and removes the filter's DC gain, G = (R·M)^N, where R is the decimation factor, M the differential delay and N the number of sections. It takes the full-precision filter output, with DIN_W + ceil(log2 Gmax) bits, and returns a sample on the scale of the original filter input, DIN_W bits wide. The block divides by G in two steps. An exponent shift removes 2^cg, where cg = floor(log2 G). A multiply by a 16-fractional-bit reciprocal of the residual G/2^cg then removes the rest. The result is rounded to nearest and saturated. No division or logarithm is computed at run time. The exponent and the reciprocal for every legal factor are computed at elaboration and held in a lookup table indexed by the factor.

In variable-rate mode, each sample brings its own decimation factor. The sample is first shifted left so that it sits at the scaling of the largest factor. It then passes through a datapath whose final right shift is fixed for the maximum gain. The factor is captured with the sample, so a change of rate never alters samples already in the pipeline. In fixed-rate mode, the factor input is ignored and the maximum factor applies. Every accepted sample comes out exactly 9 cycles later, and back-to-back samples are supported.

Top module: `cic_gain_corrector`

## Requirements
- R1: `out_valid` is high in a cycle exactly when `in_valid` was high 9 cycles earlier, including on consecutive cycles.
- R2: For a factor R in 2..R_MAX with gain G = (R·M)^N, cg = floor(log2 G) and K = round(2^(cg+16)/G), the output is floor((x·K + 2^(cg+15)) / 2^(cg+16)), then saturated as in R6. Here x is the signed input.
- R3: When G is a power of two, K is 65536 and the output equals x/G rounded to nearest, with ties going toward plus infinity.
- R4: In variable-rate mode, the factor is sampled together with each valid sample. A sample is corrected with its own factor even when the factor changes on every cycle.
- R5: A factor below 2 is treated as 2, and a factor above R_MAX is treated as R_MAX.
- R6: A result outside the signed DIN_W range is clamped to the largest positive or most negative value.
- R7: While `out_valid` is low, `out_data` keeps its previous value.
- R8: While `rst_n` is low, `out_valid` and `out_data` are both 0.
- R9: In fixed-rate mode (VAR_RATE = 0), `in_factor` has no effect, and every sample is corrected with R = R_MAX.
- R10: A zero input gives a zero output. A negative input never gives a positive output, and a positive input never gives a negative output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | IN_W | Full-precision signed filter output |
| in_valid | input | 1 | Marks a sample on `in_data` |
| in_factor | input | RW | Decimation factor for this sample (variable-rate mode) |
| out_data | output | DIN_W | Gain-corrected signed sample |
| out_valid | output | 1 | Marks a sample on `out_data` |

## Verification
For every factor from 2 to 16, the bench drives a stride sweep across the full input range. It adds values that sit on rounding ties, values at ±G/2 and ±3G/2, and values at the saturation edges. A design with a mis-rounded reciprocal, or with rounding at the wrong bit, would be off by one on those ties. A missing clamp would wrap large values into the wrong sign. Out-of-range factors check the clamp of the table index, since a table without that clamp would read undefined entries. A phase with a new random factor on every cycle and gaps in the valid strobe catches a design that looks up the factor at the output instead of capturing it with the sample. That design would correct in-flight samples with the wrong gain, and a latency error would show as a misplaced `out_valid`.

// File: rtl/gcorr_pkg.sv
`timescale 1ns/1ps
package gcorr_pkg;

  // fractional bits of the stored fine-gain reciprocals
  localparam int FRAC_BITS = 16;

  // DC gain of the decimator: (r*m)^n
  function automatic longint unsigned gain_of(int r, int m, int n);
    longint unsigned g;
    g = 1;
    for (int i = 0; i < n; i++) g = g * longint'(r * m);
    return g;
  endfunction

  // floor(log2(v)), v >= 1
  function automatic int flog2_ul(longint unsigned v);
    int k;
    longint unsigned t;
    k = 0;
    t = v;
    while (t > 1) begin
      t = t >> 1;
      k++;
    end
    return k;
  endfunction

  // ceil(log2(v)), v >= 1
  function automatic int clog2_ul(longint unsigned v);
    int k;
    longint unsigned p;
    k = 0;
    p = 1;
    while (p < v) begin
      p = p << 1;
      k++;
    end
    return k;
  endfunction

  // round(2^(cg+FRAC_BITS) / g): fine-gain inverse in (0.5, 1] as Q.FRAC_BITS
  function automatic longint unsigned recip_of(longint unsigned g);
    int c;
    longint unsigned num;
    c   = flog2_ul(g);
    num = 64'd1 << (c + FRAC_BITS);
    return (num + g / 2) / g;
  endfunction

endpackage

// File: rtl/gc_lut.sv
`timescale 1ns/1ps
// Elaboration-built table of alignment shifts and fine reciprocals,
// read through a registered port.
module gc_lut import gcorr_pkg::*; #(
  parameter int R_MAX    = 16,
  parameter int M_DLY    = 1,
  parameter int N_SEC    = 3,
  parameter int VAR_RATE = 1,
  parameter int RW       = 5,
  parameter int CGMAX    = 12,
  parameter int SHW      = 4,
  parameter int KW       = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [RW-1:0]  factor,
  output logic [SHW-1:0] align_sh,
  output logic [KW-1:0]  recip
);

  logic [SHW-1:0] tbl_sh [R_MAX+1];
  logic [KW-1:0]  tbl_k  [R_MAX+1];
  logic [RW-1:0]  eff;
  logic [SHW-1:0] sh_d;
  logic [KW-1:0]  k_d;

  for (genvar r = 0; r <= R_MAX; r++) begin : g_ent
    localparam int              RE = (r < 2) ? 2 : r;
    localparam longint unsigned GE = gain_of(RE, M_DLY, N_SEC);
    assign tbl_sh[r] = SHW'(CGMAX - flog2_ul(GE));
    assign tbl_k[r]  = KW'(recip_of(GE));
  end

  if (VAR_RATE != 0) begin : g_var
    always_comb begin
      if (factor < RW'(2))          eff = RW'(2);
      else if (factor > RW'(R_MAX)) eff = RW'(R_MAX);
      else                          eff = factor;
    end
  end else begin : g_fix
    assign eff = RW'(R_MAX);
  end

  always_comb begin
    sh_d = en ? tbl_sh[eff] : align_sh;
    k_d  = en ? tbl_k[eff]  : recip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_sh <= '0;
      recip    <= '0;
    end else begin
      align_sh <= sh_d;
      recip    <= k_d;
    end
  end

endmodule

// File: rtl/gc_pipe.sv
`timescale 1ns/1ps
// Delay line with valid tag; each data stage loads only when its
// incoming tag is set.
module gc_pipe #(
  parameter int W = 8,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic [W-1:0] d_out,
  output logic         v_out
);

  if (D == 0) begin : g_pass
    assign d_out = d_in;
    assign v_out = v_in;
  end else begin : g_chain
    logic [W-1:0] dq [D];
    logic [D-1:0] vq;

    for (genvar i = 0; i < D; i++) begin : g_st
      logic [W-1:0] src_d;
      logic         src_v;
      logic [W-1:0] nxt_d;

      if (i == 0) begin : g_head
        assign src_d = d_in;
        assign src_v = v_in;
      end else begin : g_body
        assign src_d = dq[i-1];
        assign src_v = vq[i-1];
      end

      assign nxt_d = src_v ? src_d : dq[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dq[i] <= '0;
          vq[i] <= 1'b0;
        end else begin
          dq[i] <= nxt_d;
          vq[i] <= src_v;
        end
      end
    end

    assign d_out = dq[D-1];
    assign v_out = vq[D-1];
  end

endmodule

// File: rtl/cic_gain_corrector.sv
`timescale 1ns/1ps
// CIC DC-gain removal: capture, table read, align, multiply (+tail),
// round/shift, saturate. Latency 5 + MUL_TAIL cycles (9 by default).
module cic_gain_corrector import gcorr_pkg::*; #(
  parameter int DIN_W    = 8,
  parameter int N_SEC    = 3,
  parameter int M_DLY    = 1,
  parameter int R_MAX    = 16,
  parameter int VAR_RATE = 1,
  parameter int MUL_TAIL = 4,
  localparam longint unsigned GMAX = gain_of(R_MAX, M_DLY, N_SEC),
  localparam int IN_W = DIN_W + clog2_ul(GMAX),
  localparam int RW   = $clog2(R_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  input  logic [RW-1:0]    in_factor,
  output logic [DIN_W-1:0] out_data,
  output logic             out_valid
);

  localparam int CGMAX   = flog2_ul(GMAX);
  localparam int SHW     = $clog2(CGMAX + 1);
  localparam int KW      = FRAC_BITS + 1;
  localparam int AW      = IN_W + CGMAX;
  localparam int PW      = AW + KW + 1;
  localparam int RNDW    = PW + 1;
  localparam int SHR     = CGMAX + FRAC_BITS;
  localparam int QW      = RNDW - SHR;
  localparam int LATENCY = 5 + MUL_TAIL;

  localparam logic signed [RNDW-1:0] HALF   = RNDW'(1) << (SHR - 1);
  localparam logic signed [QW-1:0]   SAT_HI = $signed({{(QW-DIN_W+1){1'b0}}, {(DIN_W-1){1'b1}}});
  localparam logic signed [QW-1:0]   SAT_LO = ~SAT_HI;

  // stage registers
  logic [IN_W-1:0]          d1_q, d2_q;
  logic [RW-1:0]            f1_q;
  logic                     v1_q, v2_q, v3_q, v4_q, v8_q, v9_q;
  logic signed [AW-1:0]     a3_q;
  logic [KW-1:0]            k3_q;
  logic signed [PW-1:0]     p4_q;
  logic signed [QW-1:0]     r8_q;
  logic [DIN_W-1:0]         o9_q;

  // next-state values
  logic [IN_W-1:0]          d1_d, d2_d;
  logic [RW-1:0]            f1_d;
  logic signed [AW-1:0]     a3_d, ext2;
  logic [KW-1:0]            k3_d;
  logic signed [PW-1:0]     p4_d;
  logic signed [RNDW-1:0]   sum7;
  logic signed [QW-1:0]     r8_d;
  logic [DIN_W-1:0]         o9_d;

  // table and multiplier tail
  logic [SHW-1:0]           sh2;
  logic [KW-1:0]            k2;
  logic [PW-1:0]            p7;
  logic                     v7;

  gc_lut #(
    .R_MAX(R_MAX), .M_DLY(M_DLY), .N_SEC(N_SEC), .VAR_RATE(VAR_RATE),
    .RW(RW), .CGMAX(CGMAX), .SHW(SHW), .KW(KW)
  ) u_lut (
    .clk(clk), .rst_n(rst_n), .en(v1_q), .factor(f1_q),
    .align_sh(sh2), .recip(k2)
  );

  gc_pipe #(.W(PW), .D(MUL_TAIL - 1)) u_tail (
    .clk(clk), .rst_n(rst_n), .d_in(p4_q), .v_in(v4_q),
    .d_out(p7), .v_out(v7)
  );

  always_comb begin
    // capture sample and its factor together
    d1_d = in_valid ? in_data   : d1_q;
    f1_d = in_valid ? in_factor : f1_q;
    d2_d = v1_q ? d1_q : d2_q;
    // lift to maximum-gain scaling
    ext2 = AW'($signed(d2_q));
    a3_d = v2_q ? (ext2 <<< sh2) : a3_q;
    k3_d = v2_q ? k2 : k3_q;
    // fine multiply by reciprocal
    p4_d = v3_q ? (a3_q * $signed({1'b0, k3_q})) : p4_q;
    // round to nearest, drop exponent and fraction bits
    sum7 = RNDW'($signed(p7)) + HALF;
    r8_d = v7 ? QW'(sum7 >>> SHR) : r8_q;
    // saturate to output width
    if (!v8_q)             o9_d = o9_q;
    else if (r8_q > SAT_HI) o9_d = SAT_HI[DIN_W-1:0];
    else if (r8_q < SAT_LO) o9_d = SAT_LO[DIN_W-1:0];
    else                    o9_d = r8_q[DIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= '0; f1_q <= '0; v1_q <= 1'b0;
      d2_q <= '0; v2_q <= 1'b0;
      a3_q <= '0; k3_q <= '0; v3_q <= 1'b0;
      p4_q <= '0; v4_q <= 1'b0;
      r8_q <= '0; v8_q <= 1'b0;
      o9_q <= '0; v9_q <= 1'b0;
    end else begin
      d1_q <= d1_d; f1_q <= f1_d; v1_q <= in_valid;
      d2_q <= d2_d; v2_q <= v1_q;
      a3_q <= a3_d; k3_q <= k3_d; v3_q <= v2_q;
      p4_q <= p4_d; v4_q <= v3_q;
      r8_q <= r8_d; v8_q <= v7;
      o9_q <= o9_d; v9_q <= v8_q;
    end
  end

  assign out_data  = o9_q;
  assign out_valid = v9_q;

endmodule

// File: rtl/gc_chk.sv
`timescale 1ns/1ps
module gc_chk #(
  parameter int IN_W  = 20,
  parameter int DIN_W = 8,
  parameter int LAT   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IN_W-1:0]  in_data,
  input logic             in_valid,
  input logic [DIN_W-1:0] out_data,
  input logic             out_valid
);

  logic [LAT-1:0] vpipe, zpipe, npipe, ppipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpipe <= '0; zpipe <= '0; npipe <= '0; ppipe <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], in_valid};
      zpipe <= {zpipe[LAT-2:0], in_valid && (in_data == '0)};
      npipe <= {npipe[LAT-2:0], in_valid && in_data[IN_W-1]};
      ppipe <= {ppipe[LAT-2:0], in_valid && !in_data[IN_W-1] && (in_data != '0)};
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vpipe[LAT-1]);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R10
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zpipe[LAT-1]) |-> (out_data == '0));

  // R10
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && npipe[LAT-1]) |-> (out_data[DIN_W-1] || out_data == '0));

  // R10
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ppipe[LAT-1]) |-> !out_data[DIN_W-1]);

  // R8
  reset_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

endmodule

bind cic_gain_corrector gc_chk #(.IN_W(IN_W), .DIN_W(DIN_W), .LAT(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
  .out_data(out_data), .out_valid(out_valid)
);

// File: tb/sim_cic_gain_corrector.sv
`timescale 1ns/1ps
module sim_cic_gain_corrector;

  localparam int DW   = 8;
  localparam int NS   = 3;
  localparam int MD   = 1;
  localparam int RMAX = 16;
  localparam int IW   = 20;
  localparam int FW   = 5;
  localparam int LAT  = 9;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] in_data;
  logic          in_valid;
  logic [FW-1:0] in_factor;
  logic [DW-1:0] out0, out1;
  logic          ov0, ov1;

  int  nchk, nfail, cyc, phase;
  bit  mon_on, done;

  logic          hv [16];
  longint        hx [16];
  int            hf [16];
  int            hp [16];
  logic [DW-1:0] prev0, prev1;

  cic_gain_corrector #(.DIN_W(DW), .N_SEC(NS), .M_DLY(MD), .R_MAX(RMAX), .VAR_RATE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_factor(in_factor), .out_data(out0), .out_valid(ov0));

  cic_gain_corrector #(.DIN_W(DW), .N_SEC(NS), .M_DLY(MD), .R_MAX(RMAX), .VAR_RATE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_factor(in_factor), .out_data(out1), .out_valid(ov1));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic longint gain_b(int r);
    longint g = 1;
    for (int i = 0; i < NS; i++) g = g * (r * MD);
    return g;
  endfunction

  function automatic int clampf(int f);
    if (f < 2) return 2;
    if (f > RMAX) return RMAX;
    return f;
  endfunction

  // unsaturated rounded result per R2
  function automatic longint raw_q(longint x, int f);
    longint g, k, q;
    int cg;
    g  = gain_b(clampf(f));
    cg = 0;
    while ((g >> (cg + 1)) != 0) cg++;
    k = ((64'sd1 <<< (cg + 16)) + g / 2) / g;
    q = (x * k + (64'sd1 <<< (cg + 15))) >>> (cg + 16);
    return q;
  endfunction

  function automatic longint sat_q(longint q);
    if (q > 127)  return 127;
    if (q < -128) return -128;
    return q;
  endfunction

  function automatic string tag_of(longint x, int f, int ph);
    longint q, g;
    if (ph == 4) return "R4";
    if (f < 2 || f > RMAX) return "R5";
    q = raw_q(x, f);
    if (q > 127 || q < -128) return "R6";
    g = gain_b(f);
    if ((g & (g - 1)) == 0) return "R3";
    return "R2";
  endfunction

  task automatic check(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // monitor: compare outputs with inputs seen LAT cycles earlier
  always @(negedge clk) begin
    if (mon_on) begin
      int o;
      o = (cyc + 16 - LAT) % 16;
      check("R1", longint'(ov0), longint'(hv[o]));
      check("R1", longint'(ov1), longint'(hv[o]));
      if (hv[o] && ov0)
        check(tag_of(hx[o], hf[o], hp[o]), longint'($signed(out0)), sat_q(raw_q(hx[o], hf[o])));
      if (hv[o] && ov1)
        check("R9", longint'($signed(out1)), sat_q(raw_q(hx[o], RMAX)));
      if (!ov0) check("R7", longint'(out0), longint'(prev0));
      if (!ov1) check("R7", longint'(out1), longint'(prev1));
      prev0 = out0;
      prev1 = out1;
      hv[cyc % 16] = in_valid;
      hx[cyc % 16] = longint'($signed(in_data));
      hf[cyc % 16] = int'(in_factor);
      hp[cyc % 16] = phase;
      cyc++;
    end
  end

  task automatic apply(longint x, int f, bit v);
    @(posedge clk);
    #1;
    in_data   = x[IW-1:0];
    in_factor = FW'(f);
    in_valid  = v;
  endtask

  initial begin
    nchk = 0; nfail = 0; cyc = 0; phase = 0;
    mon_on = 0; done = 0;
    prev0 = '0; prev1 = '0;
    for (int i = 0; i < 16; i++) begin
      hv[i] = 1'b0; hx[i] = 0; hf[i] = 2; hp[i] = 0;
    end
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; in_factor = FW'(2);
    repeat (4) @(posedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    // R8: reset state, even with a sample offered
    check("R8", longint'(ov0), 0);
    check("R8", longint'(out0), 0);
    check("R8", longint'(ov1), 0);
    check("R8", longint'(out1), 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    rst_n = 1'b1;
    mon_on = 1;

    // R2, R3, R6: every legal factor, specials plus stride sweep
    for (int r = 2; r <= RMAX; r++) begin
      longint g;
      g = gain_b(r);
      apply(0, r, 1);            // R10 zero
      apply(1, r, 1);
      apply(-1, r, 1);
      apply(g / 2, r, 1);        // rounding tie
      apply(-(g / 2), r, 1);
      apply(g / 2 - 1, r, 1);
      apply(-(g / 2) - 1, r, 1);
      apply(3 * g / 2, r, 1);
      apply(-(3 * g / 2), r, 1);
      apply(127 * g, r, 1);
      apply(-128 * g, r, 1);
      apply(524287, r, 1);       // R6 saturation edges
      apply(-524288, r, 1);
      for (int j = 0; j < 1024; j++) apply(-524288 + j * 1023, r, 1);
    end

    // R5: out-of-range factors
    for (int f = 0; f < 32; f++) begin
      if (f < 2 || f > RMAX)
        for (int j = 0; j < 32; j++) apply(-524288 + j * 32749, f, 1);
    end

    // R4, R1: factor changes every cycle, gaps in valid
    phase = 4;
    for (int j = 0; j < 3000; j++) begin
      longint x;
      x = longint'($signed(IW'($urandom)));
      apply(x, 2 + int'($urandom_range(RMAX - 2)), ($urandom_range(9) < 7));
    end
    phase = 0;
    for (int j = 0; j < 20; j++) apply(0, 2, 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule